// File: doc/BRIEF.md
# Fixed-Priority Arbiter for a Shared Bidirectional PHY Word Port

This block decides which of three agents inside a MAC accelerator may use a shared 16-bit parallel port to the PHY. The port is bidirectional. Its data lines are split into a driven output, an output enable and a sampled input, with separate write and read strobes and one acknowledge line coming back from the PHY. The three agents are outgoing frame words, PHY parameter accesses and incoming frame words. When the machine is idle it grants the port by a fixed ranking. Outgoing frame words rank first, parameter accesses second and incoming frame words last. The owner keeps the grant until its word or its burst is finished.

A parameter access always runs as one sequence that cannot be interrupted. The sequence is one word written to the PHY, a turnaround cycle, and then one word read back. The word read back goes to the requester together with a single-cycle valid pulse. Every word moves on a strobe/acknowledge handshake. If the acknowledge does not come within a bounded wait, the transfer is abandoned, a one-cycle timeout pulse is raised and the machine returns to idle. After reset the machine stays quiet for a fixed number of cycles before its first arbitration.

Top module: `phy_port_arb`

## Requirements
- R1: After reset is released, no grant, no strobe and no bus drive appear for RST_HOLD clock edges. The machine then becomes idle, and a request that is already pending is granted one edge later. The first grant is therefore visible after edge RST_HOLD+1.
- R2: In idle, a pending outgoing-frame request wins over every other request.
- R3: In idle, a pending parameter request wins over an incoming-frame request.
- R4: An incoming-frame request is granted only when no other request is pending in idle. With no request pending, nothing is granted.
- R5: An owner keeps the port until its burst ends. An outgoing burst continues while tx_req=1 and tx_last=0 at the acknowledged word. An incoming burst continues while rx_req=1 and rx_last=0 at the acknowledged word. Requests from any other agent that arrive meanwhile have no effect until idle.
- R6: A parameter write, once acknowledged, is always followed by exactly one turnaround cycle and then one read from the PHY. No other agent can be granted between the write and the read. The word read back appears on rd_word, with ctl_rd_valid high for one cycle.
- R7: bus_oe is high only while a write strobe is active. Every change of direction has at least one cycle between the two transfers in which bus_oe is low and no strobe is high.
- R8: A strobe stays high until phy_ack is sampled high, and the word completes at that edge. tx_word_taken is high exactly in the cycle in which an outgoing word is acknowledged.
- R9: If a strobe has been high for ACK_LIMIT cycles without an acknowledge, the transfer is abandoned. xfer_timeout pulses for one cycle, all grants drop, and an abandoned parameter write is not followed by a read.
- R10: At most one grant is high at a time, and the write and read strobes are never high together.
- R11: An incoming word is captured on the acknowledged edge. It is presented on rd_word with rx_valid high for one cycle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_req | input | 1 | Outgoing frame word pending |
| tx_last | input | 1 | Current outgoing word ends the burst |
| tx_data | input | DATA_W | Outgoing frame word, held until taken |
| tx_gnt | output | 1 | Port owned by the outgoing-frame agent |
| tx_word_taken | output | 1 | Current outgoing word acknowledged this cycle |
| ctl_req | input | 1 | Parameter write/read-back pending |
| ctl_data | input | DATA_W | Parameter word to write |
| ctl_gnt | output | 1 | Port owned by the parameter agent |
| ctl_rd_valid | output | 1 | rd_word holds the read-back word (one cycle) |
| rx_req | input | 1 | Incoming frame word wanted |
| rx_last | input | 1 | Current incoming word ends the burst |
| rx_gnt | output | 1 | Port owned by the incoming-frame agent |
| rx_valid | output | 1 | rd_word holds an incoming frame word (one cycle) |
| rd_word | output | DATA_W | Last word captured from the PHY |
| bus_out | output | DATA_W | Value driven onto the shared data lines |
| bus_oe | output | 1 | Drive enable for the shared data lines |
| bus_in | input | DATA_W | Value sampled from the shared data lines |
| phy_wr_stb | output | 1 | Write strobe towards the PHY |
| phy_rd_stb | output | 1 | Read strobe towards the PHY |
| phy_ack | input | 1 | PHY acknowledge of the current word |
| xfer_timeout | output | 1 | One-cycle pulse: a transfer was abandoned |

## Verification
The bench builds the block with DATA_W=16, RST_HOLD=4 and ACK_LIMIT=6. With these values the reset quiet period and the acknowledge window are short enough to sweep completely. Every acknowledge latency from zero up to and past the window is applied, so the point where a transfer stops completing and starts timing out is checked on both sides. All eight combinations of simultaneous requests are applied from idle, and the full order of completed words is compared with the ranking. Bursts with other agents' requests arriving mid-burst cover the no-preemption rule, the atomic write/read-back sequence and the turnaround gaps.

// File: rtl/phy_port_arb_pkg.sv
package phy_port_arb_pkg;

   typedef enum logic [2:0] {
      ST_QUIET,
      ST_IDLE,
      ST_WRITE,
      ST_TURN,
      ST_READ
   } arb_state_t;

   // requester slots, lower index ranks higher
   localparam int NUM_SRC = 3;
   localparam int SRC_TX  = 0;
   localparam int SRC_CTL = 1;
   localparam int SRC_RX  = 2;

endpackage

// File: rtl/phy_arb_hold.sv
module phy_arb_hold #(
   parameter int HOLD_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic hold_done
);

   initial begin
      assert (HOLD_CYC >= 1) else $error("HOLD_CYC must be at least 1");
   end

   generate
      if (HOLD_CYC == 1) begin : g_single
         assign hold_done = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(HOLD_CYC + 1);
         localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (cnt != LAST)
               cnt <= cnt + CW'(1);
         end

         assign hold_done = (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/phy_arb_pick.sv
module phy_arb_pick #(
   parameter int N = 3
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] win
);

   initial begin
      assert (N >= 1) else $error("N must be at least 1");
   end

   logic [N:0] taken;
   assign taken[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_rank
         assign win[i]     = req[i] & ~taken[i];
         assign taken[i+1] = taken[i] | req[i];
      end
   endgenerate

endmodule

// File: rtl/phy_arb_wdog.sv
module phy_arb_wdog #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic expire
);

   initial begin
      assert (LIMIT >= 2) else $error("LIMIT must be at least 2");
   end

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || clr)
         cnt <= '0;
      else
         cnt <= cnt + CW'(1);
   end

   assign expire = run && (cnt == LAST);

endmodule

// File: rtl/phy_port_arb.sv
module phy_port_arb
   import phy_port_arb_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int RST_HOLD  = 8,
   parameter int ACK_LIMIT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_req,
   input  logic              tx_last,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_gnt,
   output logic              tx_word_taken,
   input  logic              ctl_req,
   input  logic [DATA_W-1:0] ctl_data,
   output logic              ctl_gnt,
   output logic              ctl_rd_valid,
   input  logic              rx_req,
   input  logic              rx_last,
   output logic              rx_gnt,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   input  logic [DATA_W-1:0] bus_in,
   output logic              phy_wr_stb,
   output logic              phy_rd_stb,
   input  logic              phy_ack,
   output logic              xfer_timeout
);

   initial begin
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
      assert (RST_HOLD >= 1) else $error("RST_HOLD must be at least 1");
      assert (ACK_LIMIT >= 2) else $error("ACK_LIMIT must be at least 2");
   end

   arb_state_t         st, st_d;
   logic [NUM_SRC-1:0] own, own_d;
   logic [NUM_SRC-1:0] req_vec, win_vec;
   logic               hold_done, expire, busy, abort;

   assign req_vec[SRC_TX]  = tx_req;
   assign req_vec[SRC_CTL] = ctl_req;
   assign req_vec[SRC_RX]  = rx_req;

   phy_arb_hold #(.HOLD_CYC(RST_HOLD)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_done (hold_done)
   );

   phy_arb_pick #(.N(NUM_SRC)) u_pick (
      .req (req_vec),
      .win (win_vec)
   );

   assign busy  = (st == ST_WRITE) || (st == ST_READ);
   assign abort = expire && !phy_ack;

   phy_arb_wdog #(.LIMIT(ACK_LIMIT)) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy),
      .clr    (phy_ack),
      .expire (expire)
   );

   always_comb begin
      st_d  = st;
      own_d = own;
      unique case (st)
         ST_QUIET: if (hold_done) st_d = ST_IDLE;
         ST_IDLE: begin
            if (|win_vec) begin
               own_d = win_vec;
               st_d  = win_vec[SRC_RX] ? ST_READ : ST_WRITE;
            end
         end
         ST_WRITE: begin
            if (phy_ack) begin
               if (own[SRC_CTL]) begin
                  st_d = ST_TURN;
               end else if (!(tx_req && !tx_last)) begin
                  st_d  = ST_IDLE;
                  own_d = '0;
               end
            end else if (abort) begin
               st_d  = ST_IDLE;
               own_d = '0;
            end
         end
         ST_TURN: st_d = ST_READ;
         ST_READ: begin
            if (phy_ack) begin
               if (!(own[SRC_RX] && rx_req && !rx_last)) begin
                  st_d  = ST_IDLE;
                  own_d = '0;
               end
            end else if (abort) begin
               st_d  = ST_IDLE;
               own_d = '0;
            end
         end
         default: begin
            st_d  = ST_IDLE;
            own_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_QUIET;
         own          <= '0;
         rd_word      <= '0;
         ctl_rd_valid <= 1'b0;
         rx_valid     <= 1'b0;
         xfer_timeout <= 1'b0;
      end else begin
         st           <= st_d;
         own          <= own_d;
         ctl_rd_valid <= (st == ST_READ) && phy_ack && own[SRC_CTL];
         rx_valid     <= (st == ST_READ) && phy_ack && own[SRC_RX];
         xfer_timeout <= abort;
         if ((st == ST_READ) && phy_ack)
            rd_word <= bus_in;
      end
   end

   assign tx_gnt        = own[SRC_TX];
   assign ctl_gnt       = own[SRC_CTL];
   assign rx_gnt        = own[SRC_RX];
   assign bus_oe        = (st == ST_WRITE);
   assign phy_wr_stb    = (st == ST_WRITE);
   assign phy_rd_stb    = (st == ST_READ);
   assign tx_word_taken = (st == ST_WRITE) && own[SRC_TX] && phy_ack;
   assign bus_out       = !bus_oe ? '0 : (own[SRC_CTL] ? ctl_data : tx_data);

   // ---------------- assertions ----------------
   p_quiet_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_QUIET) |-> (!bus_oe && !phy_wr_stb && !phy_rd_stb && !tx_gnt && !ctl_gnt && !rx_gnt))
      else $error("R1 activity during reset hold");

   p_no_preempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_gnt && phy_wr_stb && phy_ack && tx_req && !tx_last) |=> (tx_gnt && phy_wr_stb))
      else $error("R5 outgoing burst broken");

   p_rx_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_gnt && phy_rd_stb && phy_ack && rx_req && !rx_last) |=> (rx_gnt && phy_rd_stb))
      else $error("R5 incoming burst broken");

   p_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_gnt && phy_wr_stb && phy_ack) |=> (ctl_gnt && !phy_wr_stb && !phy_rd_stb) ##1 (ctl_gnt && phy_rd_stb))
      else $error("R6 write/read-back chain broken");

   p_ctl_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd_valid |=> !ctl_rd_valid)
      else $error("R6 read-back valid longer than one cycle");

   p_turn_to_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_rd_stb) |-> !$past(bus_oe))
      else $error("R7 read began without turnaround");

   p_turn_to_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> !$past(phy_rd_stb))
      else $error("R7 write began without turnaround");

   p_wait_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_wr_stb && !phy_ack && !expire) |=> phy_wr_stb)
      else $error("R8 write strobe dropped before acknowledge");

   p_tmo_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_timeout |=> !xfer_timeout)
      else $error("R9 timeout pulse too long");

   p_tmo_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_timeout |-> (!tx_gnt && !ctl_gnt && !rx_gnt && !phy_rd_stb))
      else $error("R9 grant kept after abort");

   p_one_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_gnt, ctl_gnt, rx_gnt}))
      else $error("R10 several grants");

   p_stb_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(phy_wr_stb && phy_rd_stb))
      else $error("R10 both strobes");

endmodule

// File: tb/phy_port_arb_tb_top.sv
`timescale 1ns/1ps
module phy_port_arb_tb_top;

   localparam int DW   = 16;
   localparam int HOLD = 4;
   localparam int LIM  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          tx_req, tx_last, tx_gnt, tx_word_taken;
   logic [DW-1:0] tx_data;
   logic          ctl_req, ctl_gnt, ctl_rd_valid;
   logic [DW-1:0] ctl_data;
   logic          rx_req, rx_last, rx_gnt, rx_valid;
   logic [DW-1:0] rd_word, bus_out, bus_in;
   logic          bus_oe, phy_wr_stb, phy_rd_stb, phy_ack, xfer_timeout;

   // stimulus state (driven by the test process only)
   int            tx_mark = 0, tx_len = 0, ctl_mark = 0, rx_mark = 0, rx_len = 0;
   bit            tx_on = 0, ctl_on = 0, rx_on = 0;
   logic [DW-1:0] tx_base = '0;
   int            lat_cfg = 0;
   // monitor state (driven by the monitor only)
   int            tx_done = 0, ctl_done = 0, rx_done = 0, rd_seq = 0, log_n = 0;
   int            logc [256];
   logic [DW-1:0] logd [256];
   logic [DW-1:0] rd_expect = '0;
   bit            rd_from_ctl = 0;
   int            ctl_vld_n = 0, rx_vld_n = 0, code = 0;
   bit            prev_tmo = 0;
   // negedge monitor
   int            turn_bad = 0, excl_bad = 0, wcnt = 0;
   bit            prev_oe = 0, prev_rd = 0;

   int n_chk = 0, n_bad = 0;

   assign tx_req   = tx_on && ((tx_done - tx_mark) < tx_len);
   assign tx_last  = (tx_done - tx_mark) == tx_len - 1;
   assign tx_data  = tx_base + DW'(tx_done - tx_mark);
   assign ctl_req  = ctl_on && (ctl_done == ctl_mark);
   assign ctl_data = 16'hC35A;
   assign rx_req   = rx_on && ((rx_done - rx_mark) < rx_len);
   assign rx_last  = (rx_done - rx_mark) == rx_len - 1;
   assign bus_in   = phy_rd_stb ? (16'hA000 | DW'(rd_seq & 16'h0FFF)) : '0;

   phy_port_arb #(.DATA_W(DW), .RST_HOLD(HOLD), .ACK_LIMIT(LIM)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .tx_req(tx_req), .tx_last(tx_last), .tx_data(tx_data), .tx_gnt(tx_gnt),
      .tx_word_taken(tx_word_taken),
      .ctl_req(ctl_req), .ctl_data(ctl_data), .ctl_gnt(ctl_gnt), .ctl_rd_valid(ctl_rd_valid),
      .rx_req(rx_req), .rx_last(rx_last), .rx_gnt(rx_gnt), .rx_valid(rx_valid),
      .rd_word(rd_word), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
      .phy_wr_stb(phy_wr_stb), .phy_rd_stb(phy_rd_stb), .phy_ack(phy_ack),
      .xfer_timeout(xfer_timeout)
   );

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // PHY model: acknowledge after lat_cfg strobe cycles, one cycle wide
   always @(negedge clk) begin
      if (!rst_n) begin
         phy_ack <= 1'b0;
         wcnt    <= 0;
      end else if ((phy_wr_stb || phy_rd_stb) && !phy_ack) begin
         if (wcnt == lat_cfg) begin
            phy_ack <= 1'b1;
            wcnt    <= 0;
         end else begin
            wcnt <= wcnt + 1;
         end
      end else begin
         phy_ack <= 1'b0;
         wcnt    <= 0;
      end
   end

   // negedge observation of turnaround (R7) and exclusivity (R10)
   always @(negedge clk) begin
      if (rst_n) begin
         if (phy_rd_stb && prev_oe) turn_bad++;
         if (bus_oe && prev_rd) turn_bad++;
         if (bus_oe && !phy_wr_stb) turn_bad++;
         if ((int'(tx_gnt) + int'(ctl_gnt) + int'(rx_gnt)) > 1) excl_bad++;
         if (phy_wr_stb && phy_rd_stb) excl_bad++;
      end
      prev_oe = bus_oe;
      prev_rd = phy_rd_stb;
   end

   // posedge monitor: completed words, captured data, timeouts
   always @(posedge clk) begin
      if (rst_n) begin
         if (phy_wr_stb && phy_ack) begin
            code = tx_gnt ? 1 : (ctl_gnt ? 2 : 9);
            logc[log_n & 255] <= code;
            logd[log_n & 255] <= bus_out;
            log_n <= log_n + 1;
            if (tx_gnt) tx_done <= tx_done + 1;
            if (ctl_gnt) ctl_done <= ctl_done + 1;
            chk(tx_word_taken == tx_gnt, "R8", "tx_word_taken at acknowledged word", int'(tx_word_taken), int'(tx_gnt));
         end else if (phy_rd_stb && phy_ack) begin
            code = ctl_gnt ? 3 : (rx_gnt ? 4 : 9);
            logc[log_n & 255] <= code;
            logd[log_n & 255] <= bus_in;
            log_n <= log_n + 1;
            rd_expect <= bus_in;
            rd_from_ctl <= ctl_gnt;
            rd_seq <= rd_seq + 1;
            if (rx_gnt) rx_done <= rx_done + 1;
         end else begin
            if (tx_word_taken) chk(0, "R8", "tx_word_taken without acknowledge", 1, 0);
         end
         if (ctl_rd_valid || rx_valid) begin
            chk(rd_word == rd_expect, ctl_rd_valid ? "R6" : "R11", "rd_word", int'(rd_word), int'(rd_expect));
            chk(ctl_rd_valid == rd_from_ctl && rx_valid == !rd_from_ctl,
                rd_from_ctl ? "R6" : "R11", "valid routing", int'({ctl_rd_valid, rx_valid}),
                rd_from_ctl ? 2 : 1);
            if (ctl_rd_valid) ctl_vld_n <= ctl_vld_n + 1;
            if (rx_valid) rx_vld_n <= rx_vld_n + 1;
         end
         if (xfer_timeout && prev_tmo) chk(0, "R9", "timeout pulse width", 2, 1);
      end
      prev_tmo <= xfer_timeout;
   end

   task automatic wait_quiet();
      int q = 0;
      for (int i = 0; i < 200 && q < 4; i++) begin
         @(negedge clk);
         if (!tx_gnt && !ctl_gnt && !rx_gnt && !tx_req && !ctl_req && !rx_req) q++;
         else q = 0;
      end
   endtask

   task automatic start(input bit t, input int tl, input bit c, input bit r, input int rl);
      tx_mark = tx_done; tx_len = tl; tx_on = t;
      ctl_mark = ctl_done; ctl_on = c;
      rx_mark = rx_done; rx_len = rl; rx_on = r;
   endtask

   initial begin
      int n, exp_n, base, stb, seen_to, vld0;
      int expc [8];

      // ---- R1: reset quiet period ----
      tx_base = 16'h1100;
      start(1, 1, 0, 0, 0);
      repeat (3) begin
         @(negedge clk);
         chk(!tx_gnt && !bus_oe && !phy_wr_stb, "R1", "quiet while reset asserted", int'(tx_gnt), 0);
      end
      rst_n = 1'b1;
      n = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         n++;
         if (tx_gnt) break;
         chk(!bus_oe && !phy_wr_stb && !phy_rd_stb, "R1", "no strobe or drive in hold", int'(bus_oe), 0);
      end
      chk(n == HOLD + 1, "R1", "edges until first grant", n, HOLD + 1);
      wait_quiet();
      chk(log_n == 1 && logc[0] == 1 && logd[0] == 16'h1100, "R1", "pending word sent after hold", int'(logd[0]), 16'h1100);
      tx_on = 0;

      // ---- R2/R3/R4: sweep of simultaneous requests ----
      for (int m = 0; m < 8; m++) begin
         lat_cfg = m % 3;
         tx_base = DW'(16'h2000 + m * 16);
         exp_n = 0;
         if (m[0]) begin expc[exp_n] = 1; exp_n++; end
         if (m[1]) begin expc[exp_n] = 2; exp_n++; expc[exp_n] = 3; exp_n++; end
         if (m[2]) begin expc[exp_n] = 4; exp_n++; end
         base = log_n;
         @(negedge clk);
         start(m[0], 1, m[1], m[2], 1);
         @(negedge clk);
         chk({rx_gnt, ctl_gnt, tx_gnt} == (m[0] ? 3'b001 : m[1] ? 3'b010 : m[2] ? 3'b100 : 3'b000),
             m[0] ? "R2" : (m[1] ? "R3" : "R4"), $sformatf("first grant for mask %0d", m),
             int'({rx_gnt, ctl_gnt, tx_gnt}), m[0] ? 1 : m[1] ? 2 : m[2] ? 4 : 0);
         wait_quiet();
         chk(log_n - base == exp_n, "R4", $sformatf("word count for mask %0d", m), log_n - base, exp_n);
         for (int k = 0; k < exp_n && k < log_n - base; k++)
            chk(logc[(base + k) & 255] == expc[k], expc[k] == 1 ? "R2" : (expc[k] == 4 ? "R4" : "R3"),
                $sformatf("order mask %0d slot %0d", m, k), logc[(base + k) & 255], expc[k]);
         start(0, 0, 0, 0, 0);
      end

      // ---- R8/R9: acknowledge latency sweep across the window ----
      for (int L = 0; L <= LIM; L++) begin
         lat_cfg = L;
         tx_base = DW'(16'h3000 + L);
         stb = 0; seen_to = 0;
         @(negedge clk);
         start(1, 1, 0, 0, 0);
         for (int i = 0; i < 4 * LIM + 8; i++) begin
            @(negedge clk);
            if (phy_wr_stb) stb++;
            if (xfer_timeout) begin
               seen_to++;
               chk(!tx_gnt, "R9", "grant dropped at timeout", int'(tx_gnt), 0);
               tx_on = 0;
            end
            if (tx_done - tx_mark == 1 && !phy_wr_stb) break;
            if (seen_to > 0 && !phy_wr_stb && i > LIM + 2) break;
         end
         if (L < LIM) begin
            chk(stb == L + 1, "R8", $sformatf("strobe cycles latency %0d", L), stb, L + 1);
            chk(seen_to == 0 && tx_done - tx_mark == 1, "R8", $sformatf("completion latency %0d", L), seen_to, 0);
         end else begin
            chk(stb == LIM, "R9", "strobe cycles before abort", stb, LIM);
            chk(seen_to == 1 && tx_done == tx_mark, "R9", "abort reported once, word not taken", seen_to, 1);
         end
         tx_on = 0;
         wait_quiet();
      end

      // ---- R9: abandoned parameter write gets no read-back ----
      lat_cfg = LIM + 2;
      vld0 = ctl_vld_n;
      base = log_n;
      @(negedge clk);
      start(0, 0, 1, 0, 0);
      seen_to = 0;
      for (int i = 0; i < 3 * LIM; i++) begin
         @(negedge clk);
         if (xfer_timeout) begin seen_to++; ctl_on = 0; end
         chk(!phy_rd_stb, "R9", "no read after abandoned write", int'(phy_rd_stb), 0);
      end
      chk(seen_to == 1 && ctl_vld_n == vld0 && log_n == base, "R9", "abandoned write result", seen_to, 1);
      ctl_on = 0;
      wait_quiet();

      // ---- R5/R6/R11: burst with mid-burst requests ----
      lat_cfg = 1;
      tx_base = 16'h5100;
      vld0 = ctl_vld_n;
      base = log_n;
      @(negedge clk);
      start(1, 3, 0, 0, 0);
      for (int i = 0; i < 100 && tx_done - tx_mark < 1; i++) @(negedge clk);
      ctl_mark = ctl_done; ctl_on = 1;
      rx_mark = rx_done; rx_len = 2; rx_on = 1;
      wait_quiet();
      expc[0] = 1; expc[1] = 1; expc[2] = 1; expc[3] = 2; expc[4] = 3; expc[5] = 4; expc[6] = 4;
      chk(log_n - base == 7, "R5", "words in mixed burst", log_n - base, 7);
      for (int k = 0; k < 7; k++)
         chk(logc[(base + k) & 255] == expc[k], k < 3 ? "R5" : "R6", $sformatf("mixed order slot %0d", k),
             logc[(base + k) & 255], expc[k]);
      for (int k = 0; k < 3; k++)
         chk(logd[(base + k) & 255] == DW'(16'h5100 + k), "R5", $sformatf("burst data %0d", k),
             int'(logd[(base + k) & 255]), 16'h5100 + k);
      chk(logd[(base + 3) & 255] == 16'hC35A, "R6", "parameter word written", int'(logd[(base + 3) & 255]), 16'hC35A);
      chk(ctl_vld_n - vld0 == 1, "R6", "one read-back valid pulse", ctl_vld_n - vld0, 1);
      start(0, 0, 0, 0, 0);

      // ---- R11: incoming burst alone ----
      lat_cfg = 0;
      vld0 = rx_vld_n;
      base = log_n;
      @(negedge clk);
      start(0, 0, 0, 1, 3);
      wait_quiet();
      chk(log_n - base == 3 && rx_done - rx_mark == 3, "R11", "incoming burst length", log_n - base, 3);
      chk(rx_vld_n - vld0 == 3, "R11", "incoming valid pulses", rx_vld_n - vld0, 3);
      start(0, 0, 0, 0, 0);
      @(negedge clk);

      chk(turn_bad == 0, "R7", "turnaround violations", turn_bad, 0);
      chk(excl_bad == 0, "R10", "exclusivity violations", excl_bad, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule